// File: doc/BRIEF.md
# EEPROM Transaction Sequencer

This block sits between a host request port and an I2C byte engine. The host issues one request: a direction, a one-byte word address and a byte count. The sequencer then breaks it into the byte commands a serial EEPROM expects. Each byte command is a 5-bit flag word with a valid strobe and one data byte. The engine answers every command with a done pulse, the acknowledge it observed and, after a read, the byte it received.

A write becomes three things in turn: the write control byte after a START, the word address, and a page of data bytes pulled from a streaming input. A read becomes the write control byte after a START, the word address, the read control byte after a repeated START, and a run of reads whose bytes stream out one by one. Only one command is in flight at a time. If the device refuses a control or address byte, the sequencer closes the bus with a STOP and reports an error.

Top module: `eeprom_seq`

## Requirements
- R1: After reset, `ready` is 1, and `eng_cmd_vld`, `rdat_valid`, `txn_done` and `txn_err` are 0.
- R2: A write with effective count N issues these commands in order: flags 0x03 with data 0xA0, flags 0x02 with the word address, N-1 data commands with flags 0x02, and a final data command with flags 0x0A. The flag bits are: bit0 START, bit1 write byte, bit2 read byte, bit3 STOP after the byte, bit4 NACK after a read.
- R3: A read with effective count N issues these commands in order: 0x03 with 0xA0, 0x02 with the word address, 0x03 with 0xA1, N-1 reads with flags 0x04, and a final read with flags 0x1C.
- R4: `eng_cmd_vld` is a one-cycle pulse. No new command is issued until `eng_done` has answered the previous one.
- R5: The write count is clipped to the range 1..PAGE (default 16). A count of 0 gives one byte, and a count above PAGE gives PAGE bytes.
- R6: The read count is clipped to the range 1..RD_MAX (default 64), in the same way.
- R7: `ready` is high only while idle. A request presented while `ready` is low is ignored and starts no commands.
- R8: If `eng_nack` is 1 with `eng_done` for a control or address command, the next command is a lone STOP (flags 0x08). The transaction then ends with `txn_err` at 1 and forwards no read bytes.
- R9: Each read byte appears on `rdat` with a one-cycle `rdat_valid`, one clock after the engine's done for that read. Bytes appear in address order.
- R10: `wdat_take` pulses together with the command pulse of each write data byte, and at no other time. That command carries the `wdat` present in that cycle.
- R11: `txn_done` pulses for one cycle, and `ready` rises at the same time, one clock after the done of the final command. `txn_err` is cleared when the next request is accepted.
- R12: A NACK on a write data byte does not abort the transaction. The page completes and `txn_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `ready` is 1 |
| req_read | input | 1 | 1 = read request, 0 = write request |
| req_addr | input | 8 | Word address |
| req_len | input | LEN_W | Requested byte count |
| ready | output | 1 | Idle and able to accept a request |
| wdat | input | 8 | Next write data byte from the stream |
| wdat_take | output | 1 | The current `wdat` is consumed this cycle |
| rdat | output | 8 | Read data byte |
| rdat_valid | output | 1 | `rdat` is valid this cycle |
| txn_done | output | 1 | Transaction finished |
| txn_err | output | 1 | Last transaction was aborted on a NACK |
| eng_cmd | output | 5 | Command flags to the byte engine |
| eng_cmd_vld | output | 1 | Command strobe |
| eng_wdata | output | 8 | Byte for the engine to send |
| eng_rdata | input | 8 | Byte received by the engine |
| eng_done | input | 1 | Engine finished the current command |
| eng_nack | input | 1 | Engine saw NACK, qualified by `eng_done` |

## Verification
The assertions assume a well-behaved byte engine. It raises `eng_done` exactly once per command, only while a command is outstanding, and only in a later cycle than the strobe. `eng_nack` and `eng_rdata` are read only in that done cycle. The bench's engine model keeps to this: it waits for each strobe and holds off a fixed number of cycles before a single-cycle done. It asserts a NACK only at a chosen command index. The request fields are sampled only at acceptance, and the bench holds them for just that cycle.

// File: rtl/eeprom_seq_pkg.sv
`timescale 1ns/1ps
package eeprom_seq_pkg;

  localparam logic [4:0] F_START = 5'b00001;
  localparam logic [4:0] F_WRITE = 5'b00010;
  localparam logic [4:0] F_READ  = 5'b00100;
  localparam logic [4:0] F_STOP  = 5'b01000;
  localparam logic [4:0] F_NACK  = 5'b10000;

  typedef enum logic [2:0] {
    PH_CTRL_WR,
    PH_WORD_ADDR,
    PH_CTRL_RD,
    PH_WR_BYTE,
    PH_RD_BYTE,
    PH_HALT
  } phase_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } st_t;

  // Effective byte count: zero becomes one, anything above cap becomes cap.
  function automatic int unsigned clip_count(int unsigned raw, int unsigned cap);
    if (raw == 0) return 1;
    if (raw > cap) return cap;
    return raw;
  endfunction

  // Flag word for one step of a transaction.
  function automatic logic [4:0] step_flags(phase_t ph, logic last);
    logic [4:0] f;
    case (ph)
      PH_CTRL_WR,
      PH_CTRL_RD:   f = F_START | F_WRITE;
      PH_WORD_ADDR: f = F_WRITE;
      PH_WR_BYTE:   f = last ? (F_WRITE | F_STOP) : F_WRITE;
      PH_RD_BYTE:   f = last ? (F_READ | F_STOP | F_NACK) : F_READ;
      default:      f = F_STOP;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/eeprom_seq_enc.sv
`timescale 1ns/1ps
module eeprom_seq_enc
  import eeprom_seq_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'b1010000
) (
  input  phase_t     phase,
  input  logic       last,
  input  logic [7:0] addr,
  input  logic [7:0] wbyte,
  output logic [4:0] cmd,
  output logic [7:0] data
);

  localparam logic [7:0] CTRL_WR_BYTE = {DEV_ID, 1'b0};
  localparam logic [7:0] CTRL_RD_BYTE = {DEV_ID, 1'b1};

  always_comb begin
    cmd = step_flags(phase, last);
    case (phase)
      PH_CTRL_WR:   data = CTRL_WR_BYTE;
      PH_WORD_ADDR: data = addr;
      PH_CTRL_RD:   data = CTRL_RD_BYTE;
      PH_WR_BYTE:   data = wbyte;
      default:      data = 8'h00;
    endcase
  end

endmodule

// File: rtl/eeprom_seq_cnt.sv
`timescale 1ns/1ps
module eeprom_seq_cnt #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] left,
  output logic             last
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (load) begin
      left <= load_val;
    end else if (dec && left != '0) begin
      left <= left - ONE;
    end
  end

  assign last = (left == ONE);

endmodule

// File: rtl/eeprom_seq_next.sv
`timescale 1ns/1ps
module eeprom_seq_next
  import eeprom_seq_pkg::*;
(
  input  phase_t phase,
  input  logic   is_rd,
  input  logic   last,
  input  logic   nack,
  output phase_t nxt_phase,
  output logic   fin,
  output logic   abort
);

  always_comb begin
    nxt_phase = phase;
    fin       = 1'b0;
    abort     = 1'b0;
    case (phase)
      PH_CTRL_WR: begin
        if (nack) begin
          nxt_phase = PH_HALT;
          abort     = 1'b1;
        end else begin
          nxt_phase = PH_WORD_ADDR;
        end
      end
      PH_WORD_ADDR: begin
        if (nack) begin
          nxt_phase = PH_HALT;
          abort     = 1'b1;
        end else begin
          nxt_phase = is_rd ? PH_CTRL_RD : PH_WR_BYTE;
        end
      end
      PH_CTRL_RD: begin
        if (nack) begin
          nxt_phase = PH_HALT;
          abort     = 1'b1;
        end else begin
          nxt_phase = PH_RD_BYTE;
        end
      end
      PH_WR_BYTE,
      PH_RD_BYTE: fin = last;
      default:    fin = 1'b1;
    endcase
  end

endmodule

// File: rtl/eeprom_seq.sv
`timescale 1ns/1ps
module eeprom_seq
  import eeprom_seq_pkg::*;
#(
  parameter int         PAGE   = 16,
  parameter int         RD_MAX = 64,
  parameter int         LEN_W  = 8,
  parameter logic [6:0] DEV_ID = 7'b1010000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_read,
  input  logic [7:0]       req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             ready,
  input  logic [7:0]       wdat,
  output logic             wdat_take,
  output logic [7:0]       rdat,
  output logic             rdat_valid,
  output logic             txn_done,
  output logic             txn_err,
  output logic [4:0]       eng_cmd,
  output logic             eng_cmd_vld,
  output logic [7:0]       eng_wdata,
  input  logic [7:0]       eng_rdata,
  input  logic             eng_done,
  input  logic             eng_nack
);

  localparam int CAP_MAX = (RD_MAX > PAGE) ? RD_MAX : PAGE;
  localparam int CNT_W   = $clog2(CAP_MAX + 1);
  localparam int unsigned WR_CAP = PAGE;
  localparam int unsigned RD_CAP = RD_MAX;

  st_t        st;
  phase_t     phase;
  phase_t     nxt_phase;
  logic       is_rd_q;
  logic [7:0] addr_q;

  // Named internal events
  logic             accept;
  logic             step_done;
  logic             data_step;
  logic             fin;
  logic             abort;
  logic             cnt_last;
  logic [CNT_W-1:0] cnt_left;
  logic [CNT_W-1:0] eff_len;

  assign ready       = (st == ST_IDLE);
  assign accept      = ready && req_valid;
  assign eng_cmd_vld = (st == ST_ISSUE);
  assign step_done   = (st == ST_WAIT) && eng_done;
  assign data_step   = step_done && (phase == PH_WR_BYTE || phase == PH_RD_BYTE);
  assign wdat_take   = eng_cmd_vld && (phase == PH_WR_BYTE);
  assign eff_len     = CNT_W'(clip_count(32'(req_len), req_read ? RD_CAP : WR_CAP));

  eeprom_seq_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (eff_len),
    .dec      (data_step),
    .left     (cnt_left),
    .last     (cnt_last)
  );

  eeprom_seq_next u_next (
    .phase     (phase),
    .is_rd     (is_rd_q),
    .last      (cnt_last),
    .nack      (eng_nack),
    .nxt_phase (nxt_phase),
    .fin       (fin),
    .abort     (abort)
  );

  eeprom_seq_enc #(.DEV_ID(DEV_ID)) u_enc (
    .phase (phase),
    .last  (cnt_last),
    .addr  (addr_q),
    .wbyte (wdat),
    .cmd   (eng_cmd),
    .data  (eng_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      phase      <= PH_CTRL_WR;
      is_rd_q    <= 1'b0;
      addr_q     <= 8'h00;
      rdat       <= 8'h00;
      rdat_valid <= 1'b0;
      txn_done   <= 1'b0;
      txn_err    <= 1'b0;
    end else begin
      rdat_valid <= 1'b0;
      txn_done   <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            st      <= ST_ISSUE;
            phase   <= PH_CTRL_WR;
            is_rd_q <= req_read;
            addr_q  <= req_addr;
            txn_err <= 1'b0;
          end
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: begin
          if (eng_done) begin
            if (phase == PH_RD_BYTE) begin
              rdat       <= eng_rdata;
              rdat_valid <= 1'b1;
            end
            if (abort) txn_err <= 1'b1;
            if (fin) begin
              st       <= ST_IDLE;
              txn_done <= 1'b1;
            end else begin
              st    <= ST_ISSUE;
              phase <= nxt_phase;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eeprom_seq_chk.sv
`timescale 1ns/1ps
module eeprom_seq_chk
  import eeprom_seq_pkg::*;
#(
  parameter int PAGE   = 16,
  parameter int RD_MAX = 64,
  parameter int CNT_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready,
  input logic             eng_cmd_vld,
  input logic [4:0]       eng_cmd,
  input logic             eng_done,
  input logic             eng_nack,
  input logic             wdat_take,
  input logic             rdat_valid,
  input logic             txn_done,
  input st_t              st,
  input phase_t           phase,
  input logic             is_rd_q,
  input logic             cnt_last,
  input logic [CNT_W-1:0] cnt_left
);

  logic pend;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else if (eng_cmd_vld) pend <= 1'b1;
    else if (eng_done) pend <= 1'b0;
  end

  assert_cmd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_vld |=> !eng_cmd_vld);

  assert_one_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_vld |-> !pend);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !eng_cmd_vld);

  assert_last_write_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wdat_take |-> (eng_cmd[3] == cnt_last));

  assert_read_ack_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_cmd_vld && eng_cmd[2]) |-> (eng_cmd[4] == eng_cmd[3]));

  assert_wr_clip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && !is_rd_q) |-> (cnt_left <= CNT_W'(PAGE)));

  assert_rd_clip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && is_rd_q) |-> (cnt_left <= CNT_W'(RD_MAX)));

  assert_halt_on_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && eng_done && eng_nack &&
     (phase == PH_CTRL_WR || phase == PH_WORD_ADDR || phase == PH_CTRL_RD))
    |=> (eng_cmd_vld && eng_cmd == F_STOP));

  assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdat_valid |=> !rdat_valid);

  assert_rd_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdat_valid |-> $past(eng_done));

  assert_take_with_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wdat_take |-> (eng_cmd_vld && eng_cmd[1] && !eng_cmd[0]));

  assert_done_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    txn_done |-> ready);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    txn_done |=> !txn_done);

endmodule

bind eeprom_seq eeprom_seq_chk #(
  .PAGE   (PAGE),
  .RD_MAX (RD_MAX),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ready       (ready),
  .eng_cmd_vld (eng_cmd_vld),
  .eng_cmd     (eng_cmd),
  .eng_done    (eng_done),
  .eng_nack    (eng_nack),
  .wdat_take   (wdat_take),
  .rdat_valid  (rdat_valid),
  .txn_done    (txn_done),
  .st          (st),
  .phase       (phase),
  .is_rd_q     (is_rd_q),
  .cnt_last    (cnt_last),
  .cnt_left    (cnt_left)
);

// File: tb/eeprom_seq_bench.sv
`timescale 1ns/1ps
module eeprom_seq_bench;

  localparam int DLY = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_read = 1'b0;
  logic [7:0] req_addr = 8'h00;
  logic [7:0] req_len = 8'h00;
  logic       ready;
  logic [7:0] wdat;
  logic       wdat_take;
  logic [7:0] rdat;
  logic       rdat_valid;
  logic       txn_done;
  logic       txn_err;
  logic [4:0] eng_cmd;
  logic       eng_cmd_vld;
  logic [7:0] eng_wdata;
  logic [7:0] eng_rdata = 8'h00;
  logic       eng_done = 1'b0;
  logic       eng_nack = 1'b0;

  eeprom_seq u_eeprom_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_read    (req_read),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .ready       (ready),
    .wdat        (wdat),
    .wdat_take   (wdat_take),
    .rdat        (rdat),
    .rdat_valid  (rdat_valid),
    .txn_done    (txn_done),
    .txn_err     (txn_err),
    .eng_cmd     (eng_cmd),
    .eng_cmd_vld (eng_cmd_vld),
    .eng_wdata   (eng_wdata),
    .eng_rdata   (eng_rdata),
    .eng_done    (eng_done),
    .eng_nack    (eng_nack)
  );

  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Engine model log
  logic [4:0] log_cmd [0:99];
  logic [7:0] log_dat [0:99];
  bit         log_take[0:99];
  int         log_n = 0;
  int         nack_idx = -1;
  int         overlap = 0;

  initial begin
    forever begin
      @(negedge clk);
      while (eng_cmd_vld) begin
        if (log_n < 100) begin
          log_cmd[log_n]  = eng_cmd;
          log_dat[log_n]  = eng_wdata;
          log_take[log_n] = wdat_take;
        end
        repeat (DLY) begin
          @(negedge clk);
          if (eng_cmd_vld) overlap++;
        end
        eng_done  = 1'b1;
        eng_nack  = (log_n == nack_idx);
        eng_rdata = 8'h30 + 8'(log_n);
        log_n++;
        @(negedge clk);
        eng_done = 1'b0;
        eng_nack = 1'b0;
      end
    end
  end

  // Write stream supplier
  int wk = 0;
  assign wdat = 8'hC0 + 8'(wk);
  initial begin
    forever begin
      @(negedge clk);
      if (wdat_take) begin
        #1;
        wk++;
      end
    end
  end

  // Output monitor
  logic [7:0] rd_log [0:99];
  int rd_n = 0;
  int done_n = 0;
  bit err_at_done = 1'b0;
  bit rdy_at_done = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (rdat_valid) begin
        if (rd_n < 100) rd_log[rd_n] = rdat;
        rd_n++;
      end
      if (txn_done) begin
        done_n++;
        err_at_done = txn_err;
        rdy_at_done = ready;
      end
    end
  end

  // Vector: [24] read, [23:16] addr, [15:8] len, [7:0] nack index (FF = none)
  localparam logic [31:0] VEC [14] = '{
    32'h00_10_01_FF,  // write 1
    32'h00_3F_04_FF,  // write 4
    32'h00_00_10_FF,  // write 16 (full page)
    32'h00_20_14_FF,  // write 20, clipped
    32'h00_05_00_FF,  // write 0 -> 1
    32'h01_40_01_FF,  // read 1
    32'h01_41_05_FF,  // read 5
    32'h01_7E_00_FF,  // read 0 -> 1
    32'h01_00_46_FF,  // read 70, clipped to 64
    32'h00_11_03_00,  // nack on write control
    32'h00_12_03_01,  // nack on word address
    32'h01_13_02_02,  // nack on read control
    32'h00_14_03_03,  // nack on a data byte, ignored
    32'h01_15_02_00   // nack on control of a read
  };

  logic [4:0] exp_cmd [0:99];
  logic [7:0] exp_dat [0:99];
  bit         exp_hasdat [0:99];
  bit         exp_take [0:99];
  int         exp_n, exp_rd, exp_err;

  task automatic build(input bit rd, input logic [7:0] addr, input int len,
                       input int nk);
    int cap, eff, hdr;
    cap = rd ? 64 : 16;
    eff = (len == 0) ? 1 : ((len > cap) ? cap : len);
    hdr = rd ? 3 : 2;
    exp_cmd[0] = 5'h03; exp_dat[0] = 8'hA0; exp_hasdat[0] = 1; exp_take[0] = 0;
    exp_cmd[1] = 5'h02; exp_dat[1] = addr;  exp_hasdat[1] = 1; exp_take[1] = 0;
    exp_cmd[2] = 5'h03; exp_dat[2] = 8'hA1; exp_hasdat[2] = 1; exp_take[2] = 0;
    for (int k = 0; k < eff; k++) begin
      exp_hasdat[hdr+k] = !rd;
      exp_take[hdr+k]   = !rd;
      exp_dat[hdr+k]    = 8'hC0 + 8'(k);
      if (rd) exp_cmd[hdr+k] = (k == eff-1) ? 5'h1C : 5'h04;
      else    exp_cmd[hdr+k] = (k == eff-1) ? 5'h0A : 5'h02;
    end
    if (nk >= 0 && nk < hdr) begin
      exp_n = nk + 2;
      exp_cmd[nk+1] = 5'h08; exp_hasdat[nk+1] = 0; exp_take[nk+1] = 0;
      exp_rd = 0;
      exp_err = 1;
    end else begin
      exp_n = hdr + eff;
      exp_rd = rd ? eff : 0;
      exp_err = 0;
    end
  endtask

  task automatic run(input logic [31:0] v, input bit inject);
    bit rd;
    int nk, d0, cnt, hold;
    string tseq, tcnt, terr;
    rd = v[24];
    nk = (v[7:0] == 8'hFF) ? -1 : int'(v[7:0]);
    build(rd, v[23:16], int'(v[15:8]), nk);
    tseq = (nk >= 0 && nk <= (rd ? 2 : 1)) ? "R8" : (rd ? "R3" : "R2");
    tcnt = rd ? "R6" : "R5";
    terr = (nk >= 0 && !(nk <= (rd ? 2 : 1))) ? "R12" : "R11";
    while (!ready) @(negedge clk);
    log_n = 0; rd_n = 0; wk = 0; overlap = 0;
    nack_idx = nk;
    d0 = done_n;
    req_read = rd; req_addr = v[23:16]; req_len = v[15:8]; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!ready, "R7", "ready after accept", int'(ready), 0);
    if (inject) begin
      @(negedge clk);
      req_read = !rd; req_len = 8'd3; req_addr = 8'hEE; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    cnt = 0;
    while (done_n == d0 && cnt < 5000) begin
      @(negedge clk);
      cnt++;
    end
    chk(done_n == d0 + 1, "R11", "txn_done count", done_n - d0, 1);
    chk(rdy_at_done, "R11", "ready with txn_done", int'(rdy_at_done), 1);
    chk(log_n == exp_n, tcnt, "command count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_cmd[i] == exp_cmd[i], tseq, $sformatf("flags of cmd %0d", i),
          int'(log_cmd[i]), int'(exp_cmd[i]));
      if (exp_hasdat[i])
        chk(log_dat[i] == exp_dat[i], (i >= (rd ? 3 : 2)) ? "R10" : tseq,
            $sformatf("data of cmd %0d", i), int'(log_dat[i]), int'(exp_dat[i]));
      chk(log_take[i] == exp_take[i], "R10", $sformatf("take at cmd %0d", i),
          int'(log_take[i]), int'(exp_take[i]));
    end
    chk(overlap == 0, "R4", "commands while one outstanding", overlap, 0);
    chk(rd_n == exp_rd, "R9", "read bytes forwarded", rd_n, exp_rd);
    for (int j = 0; j < exp_rd && j < rd_n; j++)
      chk(rd_log[j] == 8'h33 + 8'(j), "R9", $sformatf("read byte %0d", j),
          int'(rd_log[j]), int'(8'h33 + 8'(j)));
    chk(int'(err_at_done) == exp_err, (exp_err != 0) ? "R8" : terr, "txn_err",
        int'(err_at_done), exp_err);
    if (inject) begin
      hold = log_n;
      repeat (30) @(negedge clk);
      chk(log_n == hold && done_n == d0 + 1, "R7", "busy request ignored",
          log_n, hold);
      chk(ready, "R7", "ready after ignored request", int'(ready), 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(ready == 1'b1, "R1", "ready in reset", int'(ready), 1);
    chk(eng_cmd_vld == 1'b0 && rdat_valid == 1'b0, "R1", "strobes in reset",
        int'({eng_cmd_vld, rdat_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txn_done == 1'b0 && txn_err == 1'b0 && ready == 1'b1, "R1",
        "state after reset", int'({txn_done, txn_err, ready}), 1);
    for (int t = 0; t < 14; t++) run(VEC[t], 1'b0);
    // R7: request while busy is dropped
    run(32'h00_22_02_FF, 1'b1);
    // R11: error cleared by the next accepted request
    run(32'h00_11_01_00, 1'b0);
    run(32'h01_23_02_FF, 1'b0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule